// File: doc/BRIEF.md
# Instruction Cache Scramble Key Renewal Controller

This controller sits next to an instruction cache whose storage is scrambled. A fence pulse from the core starts a renewal. The controller raises a key request and holds it until the key source reports a fresh key. It then captures that key and clears the valid bits of every cache set, one set per cycle. From the fence until the last set is cleared, it forces every cache lookup to miss, so instruction fetch goes straight to memory while the renewal runs in the background.

Reset is treated like a fence: the controller comes out of reset already requesting a key, and it allows no hits until a full sweep has completed. A fence that arrives while the request is still open is dropped. A fence that arrives during the sweep abandons the sweep and starts over with a new request. A one-bit key status, sampled from the key-valid input on every cycle, is exported for a control/status register. When the cache or the security option is disabled by parameter, this status is tied to zero. The handshake inputs are assumed to be synchronous to the controller clock already.

Top module: `icache_key_renew`

## Requirements
- R1: While reset is asserted and right after it is released, the key request and the forced-miss output are high, the tag write strobe is low, the captured key is zero and the status bit is zero.
- R2: Once raised, the key request stays high on every cycle until the key-valid input has been sampled high, and it is low on the cycle after that sample.
- R3: The key data is captured only on a clock edge where the request and key-valid are both high; key-valid while the request is low leaves the captured key unchanged.
- R4: On the cycle after a key is accepted, the sweep begins. The tag write strobe is high with the way mask all ones, and the set index counts 0, 1, ... NUM_SETS-1 over consecutive cycles.
- R5: The forced-miss output is high from the cycle after a fence, or after reset, until the last set has been written. It is low from the next cycle on, and the tag write strobe is never high while forced-miss is low.
- R6: A fence that arrives while the key request is open has no effect: the request stays high, and the following sweep is unchanged.
- R7: A fence that arrives during the sweep ends it. On the next cycle the key request is high, the write strobe is low, and no further set is written until a new key is accepted.
- R8: A fence in the idle state raises the key request and the forced-miss output on the next cycle.
- R9: On every cycle, in every state, the status output equals the key-valid input sampled at the previous clock edge.
- R10: With CACHE_PRESENT or SECURE_EN set to 0, the status output is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fence_i | input | 1 | One-cycle fence pulse from the core |
| key_req_o | output | 1 | Request for a fresh scrambling key |
| key_vld_i | input | 1 | Key source reports a fresh key |
| key_data_i | input | KEY_W | Key value offered with key_vld_i |
| key_o | output | KEY_W | Captured key for the scrambling datapath |
| tag_we_o | output | 1 | Tag/valid array write strobe |
| tag_idx_o | output | SET_W | Set index being cleared |
| tag_way_mask_o | output | NUM_WAYS | Ways written; the written valid bits are zero |
| force_miss_o | output | 1 | Forces every lookup to miss |
| key_sts_o | output | 1 | Key-valid status for the control/status register |

## Verification
A scripted cycle table applies several patterns. In the first, a fence lands in the middle of an open request; this separates dropping a fence from restarting. In the second, key-valid is held high through the start of a sweep, which shows that capture is gated by the request. The third is a fence inside a sweep, which tests whether the sweep truly aborts and restarts with a fresh request rather than finishing. Directed steps then cover the long wait for a key, a fence while idle, and a reset in the middle of a sweep. A second instance with security disabled runs alongside and shows that its status stays at zero.

// File: rtl/key_renew_pkg.sv
package key_renew_pkg;

  typedef enum logic [1:0] {
    RS_IDLE  = 2'd0,
    RS_KEYRQ = 2'd1,
    RS_SWEEP = 2'd2
  } renew_st_e;

  // forced miss covers both busy phases
  function automatic logic busy_state(input renew_st_e st);
    return st != RS_IDLE;
  endfunction

endpackage

// File: rtl/key_sweep_walker.sv
module key_sweep_walker #(
  parameter int NUM_SETS = 16,
  localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             step_i,
  output logic [SET_W-1:0] idx_o,
  output logic             last_o
);

  localparam logic [SET_W-1:0] LAST_IDX = SET_W'(NUM_SETS - 1);

  function automatic logic [SET_W-1:0] bump(input logic [SET_W-1:0] v);
    return v + SET_W'(1);
  endfunction

  logic [SET_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (start_i) idx_q <= '0;
    else if (step_i && !last_o) idx_q <= bump(idx_q);
  end

  assign idx_o  = idx_q;
  assign last_o = (idx_q == LAST_IDX);

  a_r4_index_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !start_i && !last_o) |=> (idx_o == $past(idx_o) + SET_W'(1)));

  a_r4_start_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (idx_o == '0));

endmodule

// File: rtl/key_renew_fsm.sv
module key_renew_fsm
  import key_renew_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fence_i,
  input  logic key_vld_i,
  input  logic sweep_last_i,
  output logic key_req_o,
  output logic key_accept_o,
  output logic sweep_step_o,
  output logic sweep_active_o,
  output logic force_miss_o
);

  renew_st_e st_q, st_d;

  // named internal events
  logic fence_drop, fence_abort, fence_start, sweep_done;

  assign fence_drop   = (st_q == RS_KEYRQ) && fence_i;
  assign fence_abort  = (st_q == RS_SWEEP) && fence_i;
  assign fence_start  = (st_q == RS_IDLE)  && fence_i;
  assign key_accept_o = (st_q == RS_KEYRQ) && key_vld_i;
  assign sweep_done   = (st_q == RS_SWEEP) && !fence_i && sweep_last_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      RS_IDLE:  if (fence_start)  st_d = RS_KEYRQ;
      RS_KEYRQ: if (key_accept_o) st_d = RS_SWEEP;
      RS_SWEEP: begin
        if (fence_abort)     st_d = RS_KEYRQ;
        else if (sweep_done) st_d = RS_IDLE;
      end
      default: st_d = RS_KEYRQ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= RS_KEYRQ;
    else         st_q <= st_d;
  end

  assign key_req_o      = (st_q == RS_KEYRQ);
  assign sweep_active_o = (st_q == RS_SWEEP);
  assign sweep_step_o   = sweep_active_o && !fence_i;
  assign force_miss_o   = busy_state(st_q);

  a_r2_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_req_o && !key_vld_i) |=> key_req_o);

  a_r2_req_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_req_o && key_vld_i) |=> !key_req_o);

  a_r6_fence_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fence_drop && !key_vld_i) |=> key_req_o);

  a_r7_abort_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fence_abort |=> (key_req_o && !sweep_active_o));

  a_r8_idle_fence: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fence_start |=> (key_req_o && force_miss_o));

  a_r5_miss_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sweep_done |=> !force_miss_o);

endmodule

// File: rtl/key_status_sample.sv
module key_status_sample #(
  parameter bit ENABLE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic key_vld_i,
  output logic sts_o
);

  if (ENABLE) begin : g_sample
    logic sts_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sts_q <= 1'b0;
      else         sts_q <= key_vld_i;
    end
    assign sts_o = sts_q;

    a_r9_status_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (sts_o == $past(key_vld_i)));
  end else begin : g_tied
    logic unused_vld;
    assign unused_vld = key_vld_i;
    assign sts_o = 1'b0;

    always_comb begin
      if (rst_ni) a_r10_status_zero: assert (sts_o == 1'b0);
    end
  end

endmodule

// File: rtl/icache_key_renew.sv
module icache_key_renew #(
  parameter int NUM_SETS      = 16,
  parameter int NUM_WAYS      = 2,
  parameter int KEY_W         = 64,
  parameter bit CACHE_PRESENT = 1'b1,
  parameter bit SECURE_EN     = 1'b1,
  localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fence_i,
  output logic                key_req_o,
  input  logic                key_vld_i,
  input  logic [KEY_W-1:0]    key_data_i,
  output logic [KEY_W-1:0]    key_o,
  output logic                tag_we_o,
  output logic [SET_W-1:0]    tag_idx_o,
  output logic [NUM_WAYS-1:0] tag_way_mask_o,
  output logic                force_miss_o,
  output logic                key_sts_o
);

  localparam bit STS_EN = CACHE_PRESENT && SECURE_EN;

  logic key_accept, sweep_step, sweep_active, sweep_last;

  key_renew_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .fence_i        (fence_i),
    .key_vld_i      (key_vld_i),
    .sweep_last_i   (sweep_last),
    .key_req_o      (key_req_o),
    .key_accept_o   (key_accept),
    .sweep_step_o   (sweep_step),
    .sweep_active_o (sweep_active),
    .force_miss_o   (force_miss_o)
  );

  key_sweep_walker #(.NUM_SETS(NUM_SETS)) u_walk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (key_accept),
    .step_i  (sweep_step),
    .idx_o   (tag_idx_o),
    .last_o  (sweep_last)
  );

  key_status_sample #(.ENABLE(STS_EN)) u_sts (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .key_vld_i (key_vld_i),
    .sts_o     (key_sts_o)
  );

  logic [KEY_W-1:0] key_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         key_q <= '0;
    else if (key_accept) key_q <= key_data_i;
  end
  assign key_o = key_q;

  assign tag_we_o       = sweep_active;
  assign tag_way_mask_o = {NUM_WAYS{sweep_active}};

  a_r3_key_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(key_req_o && key_vld_i) |=> $stable(key_o));

  a_r3_key_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_req_o && key_vld_i) |=> (key_o == $past(key_data_i)));

  a_r5_write_in_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_we_o |-> force_miss_o);

endmodule

// File: tb/icache_key_renew_tb.sv
module icache_key_renew_tb;

  localparam int NSETS = 4;
  localparam int NWAYS = 2;
  localparam int KW    = 64;
  localparam int SW    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fence = 1'b0, kvld = 1'b0;
  logic [KW-1:0] kdata = '0;

  logic          req, we, miss, sts;
  logic [KW-1:0] key;
  logic [SW-1:0] idx;
  logic [NWAYS-1:0] mask;
  logic          req_off, we_off, miss_off, sts_off;
  logic [KW-1:0] key_off;
  logic [SW-1:0] idx_off;
  logic [NWAYS-1:0] mask_off;

  int nchk = 0, nfail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  icache_key_renew #(.NUM_SETS(NSETS), .NUM_WAYS(NWAYS), .KEY_W(KW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fence_i(fence), .key_req_o(req),
    .key_vld_i(kvld), .key_data_i(kdata), .key_o(key), .tag_we_o(we),
    .tag_idx_o(idx), .tag_way_mask_o(mask), .force_miss_o(miss),
    .key_sts_o(sts));

  icache_key_renew #(.NUM_SETS(NSETS), .NUM_WAYS(NWAYS), .KEY_W(KW),
                     .SECURE_EN(1'b0)) u_dut_off (
    .clk_i(clk), .rst_ni(rst_n), .fence_i(fence), .key_req_o(req_off),
    .key_vld_i(kvld), .key_data_i(kdata), .key_o(key_off), .tag_we_o(we_off),
    .tag_idx_o(idx_off), .tag_way_mask_o(mask_off), .force_miss_o(miss_off),
    .key_sts_o(sts_off));

  // {fence, kvld, exp_req, exp_miss, exp_we, exp_sts, exp_idx[3:0]}
  localparam logic [9:0] VEC [16] = '{
    10'b0011000000, // request open
    10'b1011000000, // R6 fence dropped
    10'b0101110000, // key accepted, set 0
    10'b0001100001,
    10'b0001100010,
    10'b0001100011,
    10'b0000000000, // sweep done, idle
    10'b1011000000, // R8 fence from idle
    10'b0101110000,
    10'b0101110001, // kvld with request low
    10'b1011000000, // R7 abort
    10'b0101110000,
    10'b0001100001,
    10'b0001100010,
    10'b0001100011,
    10'b0000000000
  };

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [KW-1:0] exp_key;
    logic prev_req;
    // R1 reset state
    tick();
    chk("R1 req", req, 1);
    chk("R1 miss", miss, 1);
    chk("R1 we", we, 0);
    chk("R1 key", key, 0);
    chk("R1 sts", sts, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 req after release", req, 1);
    chk("R1 miss after release", miss, 1);

    exp_key = '0;
    prev_req = 1'b1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      fence = VEC[i][9];
      kvld  = VEC[i][8];
      kdata = 64'hC0DE_5A5A_0000_0000 | 64'(i);
      if (prev_req && kvld) exp_key = kdata;   // R3 capture rule
      tick();
      chk("R2/R6/R7/R8 req", req, VEC[i][7]);
      chk("R5 miss", miss, VEC[i][6]);
      chk("R4/R7 we", we, VEC[i][5]);
      chk("R9 sts", sts, VEC[i][4]);
      chk("R10 sts off", sts_off, 0);
      chk("R3 key", key, exp_key);
      if (VEC[i][5]) begin
        chk("R4 idx", idx, VEC[i][SW-1:0]);
        chk("R4 mask", mask, {NWAYS{1'b1}});
      end
      prev_req = VEC[i][7];
    end

    // R8 fence while idle, then R2 long wait
    @(negedge clk);
    fence = 1'b1; kvld = 1'b0;
    tick();
    chk("R8 req", req, 1);
    chk("R8 miss", miss, 1);
    @(negedge clk);
    fence = 1'b0;
    for (int j = 0; j < 6; j++) begin
      tick();
      chk("R2 req held", req, 1);
      chk("R5 no write yet", we, 0);
    end
    @(negedge clk);
    kvld = 1'b1; kdata = 64'h1234_5678_9ABC_DEF0;
    tick();
    chk("R2 req low", req, 0);
    chk("R3 key", key, 64'h1234_5678_9ABC_DEF0);
    chk("R9 sts", sts, 1);
    chk("R10 sts off", sts_off, 0);
    @(negedge clk);
    kvld = 1'b0;
    tick();
    chk("R4 idx 1", idx, 1);
    // reset in the middle of the sweep
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 req mid reset", req, 1);
    chk("R1 we mid reset", we, 0);
    chk("R1 key mid reset", key, 0);
    chk("R1 sts mid reset", sts, 0);
    @(negedge clk);
    rst_n = 1'b1;
    tick();

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule